// File: doc/BRIEF.md
# Branch Resolution and Squash Controller

This block sits in the execute stage of an in-order pipeline. Each cycle it sees up to `N` execute requests, one per slot. Each request carries a sequence number, a thread id, a program counter, a resolved target and a set of class and outcome flags. Two per-cycle rules decide which requests are accepted. First, a serializing instruction shuts out every later slot in the same cycle. Second, at most one control transfer is accepted per cycle. A refused request sees `done_o` low and must be offered again in a later cycle. Slots are evaluated lowest index first, and all per-cycle state is forgotten at each clock edge.

An accepted control transfer can be mispredicted and fault-free. In that case, one cycle later the block issues a fetch redirect and a squash broadcast. The broadcast carries the thread id, the stage number and a boundary sequence number. The boundary depends on two things: whether the machine has delay slots, and whether the branch has an annulling delay slot. The ALU result and fault status come in as inputs.

Saturating counters record five things: mispredictions predicted taken, mispredictions predicted not-taken, total mispredictions, correct predictions and fault-free executions. Software can form the misprediction ratio from these counters.

Top module: `brsq_ctrl`

## Requirements
- R1: When a slot is accepted with `ser_i` set, every higher-indexed slot in the same cycle has `done_o` low.
- R2: At most one request with `ctrl_i` set is accepted per cycle. A later control slot in that cycle is refused even if an earlier slot's control transfer is the one that squashes.
- R3: A valid request with `mem_i` set is never accepted. `err_mem_o` is high in the cycle after any such request.
- R4: For an accepted, fault-free, mispredicted control transfer with `cdelay_i` low, `squash_seq_o` is the sequence number plus 1 (modulo 2^SEQ_W) when `DELAY_SLOTS`=1. It is the sequence number itself when `DELAY_SLOTS`=0.
- R5: With `cdelay_i` high, the boundary is the branch's own sequence number in either configuration. `dslot_keep_o` is high exactly when `cdelay_i` is high and `ptaken_i` is low.
- R6: One cycle after such a branch is accepted, `squash_valid_o` is high. In that cycle `redirect_pc_o` is `tgt_i` if `rtaken_i` is set and `pc_i + PC_STEP` otherwise, and `squash_tid_o` and `squash_stage_o` carry the branch's tid and `stage_i`. At all other times `squash_valid_o` is low.
- R7: An accepted, fault-free request with `mispred_i` set and `ctrl_i` clear raises `err_fatal_o` in the next cycle and produces no squash.
- R8: An accepted request with `fault_i` set has `fault_o` high in the same cycle. It produces no squash and no counter update.
- R9: Counters update at the edge after acceptance. Taken-wrong counts mispredicted branches with `ptaken_i`=1, and not-taken-wrong those with `ptaken_i`=0. Wrong counts all mispredicted branches, right counts correctly predicted control transfers, and exec counts fault-free accepted requests.
- R10: Counters saturate at 2^CNT_W-1 and never decrease outside reset.
- R11: Acceptance is evaluated in slot order, and a request that is valid, not a memory reference and not blocked by R1 or R2 is accepted.
- R12: After reset all counters, `squash_valid_o`, `err_mem_o` and `err_fatal_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | N | Request present per slot |
| seq_i | input | N*SEQ_W | Sequence number per slot |
| tid_i | input | N*TID_W | Thread id per slot |
| pc_i | input | N*PC_W | Instruction PC per slot |
| tgt_i | input | N*PC_W | Resolved taken target per slot |
| ctrl_i | input | N | Control-transfer instruction |
| ser_i | input | N | Serialize-after instruction |
| mem_i | input | N | Memory reference (illegal here) |
| cdelay_i | input | N | Branch with annulling delay slot |
| ptaken_i | input | N | Predicted taken |
| mispred_i | input | N | Prediction found wrong |
| rtaken_i | input | N | Resolved taken |
| fault_i | input | N | Execution faulted |
| stage_i | input | STAGE_W | Stage number of this unit |
| done_o | output | N | Request accepted this cycle |
| fault_o | output | N | Accepted request reported a fault |
| squash_valid_o | output | 1 | Squash and redirect pulse |
| squash_seq_o | output | SEQ_W | Squash boundary sequence number |
| squash_tid_o | output | TID_W | Thread being squashed |
| squash_stage_o | output | STAGE_W | Stage where squash starts |
| redirect_pc_o | output | PC_W | Fetch redirect target |
| dslot_keep_o | output | 1 | Downstream must process the delay slot |
| err_mem_o | output | 1 | Memory reference was presented |
| err_fatal_o | output | 1 | Non-control instruction flagged mispredicted |
| cnt_pt_wrong_o | output | CNT_W | Mispredicts predicted taken |
| cnt_pnt_wrong_o | output | CNT_W | Mispredicts predicted not-taken |
| cnt_wrong_o | output | CNT_W | Total mispredicts |
| cnt_right_o | output | CNT_W | Correct predictions |
| cnt_exec_o | output | CNT_W | Fault-free executions |

## Verification
The hardest situations to reach are the slot-ordering interactions. Examples are a serializing instruction shadowing a later control transfer, a second control transfer arriving behind an accepted one, and a memory reference sitting behind a barrier. These only appear when several slots present particular flag mixes in the same cycle. The bench reaches all of them by sweeping every combination of valid, serialize, control and memory flags across three slots. For each combination it predicts acceptance from the rules, and it lets the exec and right counters run into saturation along the way. A second sweep walks each slot through every combination of annulling delay slot, predicted direction and resolved direction. It drives two instances, one with delay slots and one without, and includes a sequence number at the wrap point.

// File: rtl/brsq_pkg.sv
package brsq_pkg;
  typedef struct packed {
    logic ctrl;
    logic ser;
    logic mem;
    logic cdelay;
    logic ptaken;
    logic mispred;
    logic rtaken;
    logic fault;
  } slot_flags_t;

  typedef enum logic [2:0] {
    CNT_PT_WRONG  = 3'd0,
    CNT_PNT_WRONG = 3'd1,
    CNT_WRONG     = 3'd2,
    CNT_RIGHT     = 3'd3,
    CNT_EXEC      = 3'd4
  } cnt_idx_e;

  localparam int unsigned NUM_CNT = 5;
endpackage

// File: rtl/brsq_admit.sv
module brsq_admit
  import brsq_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] valid_i,
  input  slot_flags_t  flags_i [N],
  output logic [N-1:0] done_o,
  output logic         mem_err_o
);
  logic [N-1:0] mem_vec;

  for (genvar i = 0; i < N; i++) begin : g_mem
    assign mem_vec[i] = valid_i[i] & flags_i[i].mem;
  end
  assign mem_err_o = |mem_vec;

  // lowest slot first; barrier and control seen live only within this cycle
  always_comb begin
    logic barrier;
    logic ctrl_seen;
    barrier   = 1'b0;
    ctrl_seen = 1'b0;
    done_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && !flags_i[i].mem && !barrier &&
          !(flags_i[i].ctrl && ctrl_seen)) begin
        done_o[i] = 1'b1;
        barrier   = barrier | flags_i[i].ser;
        ctrl_seen = ctrl_seen | flags_i[i].ctrl;
      end
    end
  end
endmodule

// File: rtl/brsq_resolve.sv
module brsq_resolve
  import brsq_pkg::*;
#(
  parameter int unsigned N           = 2,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned TID_W       = 2,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned PC_STEP     = 4,
  parameter bit          DELAY_SLOTS = 1'b1
) (
  input  logic [N-1:0]       done_i,
  input  slot_flags_t        flags_i [N],
  input  logic [N*SEQ_W-1:0] seq_i,
  input  logic [N*TID_W-1:0] tid_i,
  input  logic [N*PC_W-1:0]  pc_i,
  input  logic [N*PC_W-1:0]  tgt_i,
  output logic               hit_o,
  output logic [SEQ_W-1:0]   bound_o,
  output logic [TID_W-1:0]   tid_o,
  output logic [PC_W-1:0]    npc_o,
  output logic               keep_o,
  output logic               fatal_o
);
  localparam logic [SEQ_W-1:0] BOUND_OFS = DELAY_SLOTS ? SEQ_W'(1) : '0;
  localparam logic [PC_W-1:0]  STEP      = PC_W'(PC_STEP);

  logic [N-1:0]     hit;
  logic [N-1:0]     fatal;
  logic [N-1:0]     keep;
  logic [SEQ_W-1:0] bound [N];
  logic [PC_W-1:0]  npc   [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [SEQ_W-1:0] seq_s;
    logic [PC_W-1:0]  pc_s;
    assign seq_s    = seq_i[i*SEQ_W +: SEQ_W];
    assign pc_s     = pc_i[i*PC_W +: PC_W];
    assign hit[i]   = done_i[i] & flags_i[i].ctrl & flags_i[i].mispred & ~flags_i[i].fault;
    assign fatal[i] = done_i[i] & ~flags_i[i].ctrl & flags_i[i].mispred & ~flags_i[i].fault;
    assign bound[i] = flags_i[i].cdelay ? seq_s : seq_s + BOUND_OFS;
    assign keep[i]  = flags_i[i].cdelay & ~flags_i[i].ptaken;
    assign npc[i]   = flags_i[i].rtaken ? tgt_i[i*PC_W +: PC_W] : pc_s + STEP;
  end

  assign hit_o   = |hit;
  assign fatal_o = |fatal;

  // descending walk so the lowest hit slot wins
  always_comb begin
    bound_o = '0;
    tid_o   = '0;
    npc_o   = '0;
    keep_o  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        bound_o = bound[i];
        tid_o   = tid_i[i*TID_W +: TID_W];
        npc_o   = npc[i];
        keep_o  = keep[i];
      end
    end
  end
endmodule

// File: rtl/brsq_stats.sv
module brsq_stats
  import brsq_pkg::*;
#(
  parameter int unsigned N     = 2,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     done_i,
  input  slot_flags_t      flags_i [N],
  output logic [CNT_W-1:0] cnt_o [NUM_CNT]
);
  localparam int unsigned INC_W = $clog2(N + 1);

  logic [N-1:0] ev [NUM_CNT];

  for (genvar i = 0; i < N; i++) begin : g_ev
    logic ok;
    assign ok = done_i[i] & ~flags_i[i].fault;
    assign ev[CNT_PT_WRONG][i]  = ok & flags_i[i].ctrl & flags_i[i].mispred & flags_i[i].ptaken;
    assign ev[CNT_PNT_WRONG][i] = ok & flags_i[i].ctrl & flags_i[i].mispred & ~flags_i[i].ptaken;
    assign ev[CNT_WRONG][i]     = ok & flags_i[i].ctrl & flags_i[i].mispred;
    assign ev[CNT_RIGHT][i]     = ok & flags_i[i].ctrl & ~flags_i[i].mispred;
    assign ev[CNT_EXEC][i]      = ok;
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    logic [INC_W-1:0] inc;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
      inc = '0;
      for (int i = 0; i < N; i++) inc = inc + INC_W'(ev[c][i]);
    end

    assign sum = {1'b0, cnt_q} + (CNT_W + 1)'(inc);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cnt_q <= '0;
      else if (sum[CNT_W]) cnt_q <= '1;
      else                 cnt_q <= sum[CNT_W-1:0];
    end

    assign cnt_o[c] = cnt_q;
  end
endmodule

// File: rtl/brsq_ctrl.sv
module brsq_ctrl
  import brsq_pkg::*;
#(
  parameter int unsigned N           = 2,
  parameter int unsigned SEQ_W       = 16,
  parameter int unsigned TID_W       = 2,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned STAGE_W     = 3,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PC_STEP     = 4,
  parameter bit          DELAY_SLOTS = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       valid_i,
  input  logic [N*SEQ_W-1:0] seq_i,
  input  logic [N*TID_W-1:0] tid_i,
  input  logic [N*PC_W-1:0]  pc_i,
  input  logic [N*PC_W-1:0]  tgt_i,
  input  logic [N-1:0]       ctrl_i,
  input  logic [N-1:0]       ser_i,
  input  logic [N-1:0]       mem_i,
  input  logic [N-1:0]       cdelay_i,
  input  logic [N-1:0]       ptaken_i,
  input  logic [N-1:0]       mispred_i,
  input  logic [N-1:0]       rtaken_i,
  input  logic [N-1:0]       fault_i,
  input  logic [STAGE_W-1:0] stage_i,
  output logic [N-1:0]       done_o,
  output logic [N-1:0]       fault_o,
  output logic               squash_valid_o,
  output logic [SEQ_W-1:0]   squash_seq_o,
  output logic [TID_W-1:0]   squash_tid_o,
  output logic [STAGE_W-1:0] squash_stage_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               dslot_keep_o,
  output logic               err_mem_o,
  output logic               err_fatal_o,
  output logic [CNT_W-1:0]   cnt_pt_wrong_o,
  output logic [CNT_W-1:0]   cnt_pnt_wrong_o,
  output logic [CNT_W-1:0]   cnt_wrong_o,
  output logic [CNT_W-1:0]   cnt_right_o,
  output logic [CNT_W-1:0]   cnt_exec_o
);
  slot_flags_t      flags [N];
  logic             mem_err;
  logic             hit;
  logic             fatal;
  logic             keep;
  logic [SEQ_W-1:0] bound;
  logic [TID_W-1:0] hit_tid;
  logic [PC_W-1:0]  npc;
  logic [CNT_W-1:0] cnt [NUM_CNT];

  for (genvar i = 0; i < N; i++) begin : g_flags
    assign flags[i] = '{ctrl: ctrl_i[i], ser: ser_i[i], mem: mem_i[i],
                        cdelay: cdelay_i[i], ptaken: ptaken_i[i],
                        mispred: mispred_i[i], rtaken: rtaken_i[i],
                        fault: fault_i[i]};
  end

  brsq_admit #(.N(N)) u_admit (
    .valid_i   (valid_i),
    .flags_i   (flags),
    .done_o    (done_o),
    .mem_err_o (mem_err)
  );

  assign fault_o = done_o & fault_i;

  brsq_resolve #(
    .N(N), .SEQ_W(SEQ_W), .TID_W(TID_W), .PC_W(PC_W),
    .PC_STEP(PC_STEP), .DELAY_SLOTS(DELAY_SLOTS)
  ) u_resolve (
    .done_i  (done_o),
    .flags_i (flags),
    .seq_i   (seq_i),
    .tid_i   (tid_i),
    .pc_i    (pc_i),
    .tgt_i   (tgt_i),
    .hit_o   (hit),
    .bound_o (bound),
    .tid_o   (hit_tid),
    .npc_o   (npc),
    .keep_o  (keep),
    .fatal_o (fatal)
  );

  brsq_stats #(.N(N), .CNT_W(CNT_W)) u_stats (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done_o),
    .flags_i (flags),
    .cnt_o   (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      squash_valid_o <= 1'b0;
      squash_seq_o   <= '0;
      squash_tid_o   <= '0;
      squash_stage_o <= '0;
      redirect_pc_o  <= '0;
      dslot_keep_o   <= 1'b0;
      err_mem_o      <= 1'b0;
      err_fatal_o    <= 1'b0;
    end else begin
      squash_valid_o <= hit;
      err_mem_o      <= mem_err;
      err_fatal_o    <= fatal;
      dslot_keep_o   <= hit & keep;
      if (hit) begin
        squash_seq_o   <= bound;
        squash_tid_o   <= hit_tid;
        squash_stage_o <= stage_i;
        redirect_pc_o  <= npc;
      end
    end
  end

  assign cnt_pt_wrong_o  = cnt[CNT_PT_WRONG];
  assign cnt_pnt_wrong_o = cnt[CNT_PNT_WRONG];
  assign cnt_wrong_o     = cnt[CNT_WRONG];
  assign cnt_right_o     = cnt[CNT_RIGHT];
  assign cnt_exec_o      = cnt[CNT_EXEC];
endmodule

// File: rtl/brsq_ctrl_chk.sv
module brsq_ctrl_chk #(
  parameter int unsigned N     = 2,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     valid_i,
  input logic [N-1:0]     ctrl_i,
  input logic [N-1:0]     ser_i,
  input logic [N-1:0]     mem_i,
  input logic [N-1:0]     mispred_i,
  input logic [N-1:0]     fault_i,
  input logic [N-1:0]     done_o,
  input logic             squash_valid_o,
  input logic             err_mem_o,
  input logic             err_fatal_o,
  input logic [CNT_W-1:0] cnt_exec_o,
  input logic [CNT_W-1:0] cnt_wrong_o
);
  logic sq_src;
  logic nc_src;
  assign sq_src = |(done_o & ctrl_i & mispred_i & ~fault_i);
  assign nc_src = |(done_o & ~ctrl_i & mispred_i & ~fault_i);

  AST_ONE_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(done_o & ctrl_i) <= 1); // R2

  for (genvar i = 0; i < N; i++) begin : g_ser
    AST_SER_BARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o[i] && ser_i[i]) |-> ((done_o >> (i + 1)) == '0)); // R1
  end

  AST_MEM_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o & mem_i) == '0); // R3

  AST_MEM_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(valid_i & mem_i)) |=> err_mem_o); // R3

  AST_SQ_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_o |-> $past(sq_src)); // R6

  AST_FAULT_NO_SQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sq_src && (|(done_o & fault_i))) |=> !squash_valid_o); // R8

  AST_NONCTRL_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nc_src |=> err_fatal_o); // R7

  AST_EXEC_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_exec_o >= $past(cnt_exec_o)); // R10

  AST_WRONG_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wrong_o >= $past(cnt_wrong_o)); // R10
endmodule

bind brsq_ctrl brsq_ctrl_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .ctrl_i         (ctrl_i),
  .ser_i          (ser_i),
  .mem_i          (mem_i),
  .mispred_i      (mispred_i),
  .fault_i        (fault_i),
  .done_o         (done_o),
  .squash_valid_o (squash_valid_o),
  .err_mem_o      (err_mem_o),
  .err_fatal_o    (err_fatal_o),
  .cnt_exec_o     (cnt_exec_o),
  .cnt_wrong_o    (cnt_wrong_o)
);

// File: tb/brsq_ctrl_bench.sv
module brsq_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int N     = 3;
  localparam int SEQ_W = 8;
  localparam int TID_W = 2;
  localparam int PC_W  = 16;
  localparam int STG_W = 3;
  localparam int CNT_W = 4;
  localparam int CMAX  = 15;

  logic clk = 1'b0;
  logic rst_ni;
  logic [N-1:0] valid_i, ctrl_i, ser_i, mem_i, cdelay_i, ptaken_i, mispred_i, rtaken_i, fault_i;
  logic [N*SEQ_W-1:0] seq_i;
  logic [N*TID_W-1:0] tid_i;
  logic [N*PC_W-1:0]  pc_i, tgt_i;
  logic [STG_W-1:0]   stage_i;

  logic [N-1:0] done_o, fault_o, done_b, fault_b;
  logic sq_v, keep, err_mem, err_fatal, sq_v_b, keep_b, err_mem_b, err_fatal_b;
  logic [SEQ_W-1:0] sq_seq, sq_seq_b;
  logic [TID_W-1:0] sq_tid, sq_tid_b;
  logic [STG_W-1:0] sq_stg, sq_stg_b;
  logic [PC_W-1:0]  rd_pc, rd_pc_b;
  logic [CNT_W-1:0] c_pt, c_pnt, c_wr, c_rt, c_ex;
  logic [CNT_W-1:0] c_pt_b, c_pnt_b, c_wr_b, c_rt_b, c_ex_b;

  int checks = 0;
  int errors = 0;
  int m_ex, m_rt, m_pt, m_pnt, m_wr;

  always #(CLK_P / 2) clk = ~clk;

  brsq_ctrl #(.N(N), .SEQ_W(SEQ_W), .TID_W(TID_W), .PC_W(PC_W), .STAGE_W(STG_W),
              .CNT_W(CNT_W), .PC_STEP(4), .DELAY_SLOTS(1'b1)) u_brsq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .seq_i(seq_i), .tid_i(tid_i),
    .pc_i(pc_i), .tgt_i(tgt_i), .ctrl_i(ctrl_i), .ser_i(ser_i), .mem_i(mem_i),
    .cdelay_i(cdelay_i), .ptaken_i(ptaken_i), .mispred_i(mispred_i), .rtaken_i(rtaken_i),
    .fault_i(fault_i), .stage_i(stage_i), .done_o(done_o), .fault_o(fault_o),
    .squash_valid_o(sq_v), .squash_seq_o(sq_seq), .squash_tid_o(sq_tid),
    .squash_stage_o(sq_stg), .redirect_pc_o(rd_pc), .dslot_keep_o(keep),
    .err_mem_o(err_mem), .err_fatal_o(err_fatal), .cnt_pt_wrong_o(c_pt),
    .cnt_pnt_wrong_o(c_pnt), .cnt_wrong_o(c_wr), .cnt_right_o(c_rt), .cnt_exec_o(c_ex));

  brsq_ctrl #(.N(N), .SEQ_W(SEQ_W), .TID_W(TID_W), .PC_W(PC_W), .STAGE_W(STG_W),
              .CNT_W(CNT_W), .PC_STEP(4), .DELAY_SLOTS(1'b0)) u_brsq_ctrl_nd (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .seq_i(seq_i), .tid_i(tid_i),
    .pc_i(pc_i), .tgt_i(tgt_i), .ctrl_i(ctrl_i), .ser_i(ser_i), .mem_i(mem_i),
    .cdelay_i(cdelay_i), .ptaken_i(ptaken_i), .mispred_i(mispred_i), .rtaken_i(rtaken_i),
    .fault_i(fault_i), .stage_i(stage_i), .done_o(done_b), .fault_o(fault_b),
    .squash_valid_o(sq_v_b), .squash_seq_o(sq_seq_b), .squash_tid_o(sq_tid_b),
    .squash_stage_o(sq_stg_b), .redirect_pc_o(rd_pc_b), .dslot_keep_o(keep_b),
    .err_mem_o(err_mem_b), .err_fatal_o(err_fatal_b), .cnt_pt_wrong_o(c_pt_b),
    .cnt_pnt_wrong_o(c_pnt_b), .cnt_wrong_o(c_wr_b), .cnt_right_o(c_rt_b), .cnt_exec_o(c_ex_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    valid_i = '0; ctrl_i = '0; ser_i = '0; mem_i = '0; cdelay_i = '0; ptaken_i = '0;
    mispred_i = '0; rtaken_i = '0; fault_i = '0; seq_i = '0; tid_i = '0;
    pc_i = '0; tgt_i = '0; stage_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    clear_in();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    m_ex = 0; m_rt = 0; m_pt = 0; m_pnt = 0; m_wr = 0;
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    do_reset();
    // R12 reset state
    #1;
    chk(sq_v == 0 && err_mem == 0 && err_fatal == 0, "R12 outputs", {sq_v, err_mem, err_fatal}, 0);
    chk({c_pt, c_pnt, c_wr, c_rt, c_ex} == '0, "R12 counters", {c_pt, c_pnt, c_wr, c_rt, c_ex}, 0);
    @(negedge clk);

    // exhaustive flag sweep: per slot {mem,ctrl,ser,valid}
    for (int p = 0; p < 4096; p++) begin
      logic [N-1:0] exp_d;
      int nacc, nctl;
      clear_in();
      for (int s = 0; s < N; s++) begin
        valid_i[s] = p[4*s];
        ser_i[s]   = p[4*s+1];
        ctrl_i[s]  = p[4*s+2];
        mem_i[s]   = p[4*s+3];
      end
      seq_i = 24'(p * 7);
      exp_d = '0;
      for (int s = 0; s < N; s++) begin
        bit acc;
        acc = valid_i[s] && !mem_i[s];
        for (int j = 0; j < s; j++) begin
          if (exp_d[j] && ser_i[j]) acc = 0;
          if (exp_d[j] && ctrl_i[j] && ctrl_i[s]) acc = 0;
        end
        exp_d[s] = acc;
      end
      #1;
      chk(done_o == exp_d, "R11 R1 R2 done", done_o, exp_d);
      chk(fault_o == '0, "R8 fault_o idle", fault_o, 0);
      nacc = $countones(exp_d);
      nctl = $countones(exp_d & ctrl_i);
      @(posedge clk); #1;
      chk(err_mem == |(valid_i & mem_i), "R3 err_mem", err_mem, |(valid_i & mem_i));
      chk(sq_v == 0, "R6 no squash", sq_v, 0);
      m_ex = sat(m_ex + nacc);
      m_rt = sat(m_rt + nctl);
      chk(c_ex == CNT_W'(m_ex), "R10 exec count", c_ex, m_ex);
      chk(c_rt == CNT_W'(m_rt), "R9 right count", c_rt, m_rt);
      @(negedge clk);
    end

    // misprediction sweep over slot, cdelay, ptaken, rtaken
    do_reset();
    for (int c = 0; c < 24; c++) begin
      int k;
      logic [SEQ_W-1:0] sq;
      logic [PC_W-1:0] pcv, tg, exp_pc;
      clear_in();
      k = c / 8;
      sq = SEQ_W'(8'hE8 + c);
      pcv = PC_W'(16'h1000 + c * 16);
      tg  = PC_W'(16'h8000 + c);
      valid_i[k] = 1; ctrl_i[k] = 1; mispred_i[k] = 1;
      cdelay_i[k] = c[0]; ptaken_i[k] = c[1]; rtaken_i[k] = c[2];
      seq_i[k*SEQ_W +: SEQ_W] = sq;
      tid_i[k*TID_W +: TID_W] = TID_W'(c);
      pc_i[k*PC_W +: PC_W] = pcv;
      tgt_i[k*PC_W +: PC_W] = tg;
      stage_i = STG_W'(c + 1);
      exp_pc = c[2] ? tg : pcv + 16'd4;
      #1;
      chk(done_o == (N'(1) << k), "R11 single branch", done_o, N'(1) << k);
      @(posedge clk); #1;
      chk(sq_v == 1 && sq_v_b == 1, "R6 squash pulse", {sq_v, sq_v_b}, 3);
      chk(sq_seq == (c[0] ? sq : sq + 8'd1), "R4 R5 bound ds", sq_seq, c[0] ? sq : sq + 8'd1);
      chk(sq_seq_b == sq, "R4 R5 bound nds", sq_seq_b, sq);
      chk(keep == (c[0] && !c[1]), "R5 keep", keep, c[0] && !c[1]);
      chk(rd_pc == exp_pc, "R6 redirect", rd_pc, exp_pc);
      chk(sq_tid == TID_W'(c) && sq_stg == STG_W'(c + 1), "R6 tid stage", {sq_tid, sq_stg}, {TID_W'(c), STG_W'(c + 1)});
      m_pt  = sat(m_pt + (c[1] ? 1 : 0));
      m_pnt = sat(m_pnt + (c[1] ? 0 : 1));
      m_wr  = sat(m_wr + 1);
      m_ex  = sat(m_ex + 1);
      chk(c_pt == CNT_W'(m_pt), "R9 pt_wrong", c_pt, m_pt);
      chk(c_pnt == CNT_W'(m_pnt), "R9 pnt_wrong", c_pnt, m_pnt);
      chk(c_wr == CNT_W'(m_wr), "R10 wrong sat", c_wr, m_wr);
      chk(c_ex == CNT_W'(m_ex), "R9 exec", c_ex, m_ex);
      @(negedge clk);
    end
    clear_in();
    @(posedge clk); #1;
    chk(sq_v == 0, "R6 pulse ends", sq_v, 0);
    @(negedge clk);

    // directed corners
    do_reset();
    clear_in();
    valid_i = 3'b001; ctrl_i = 3'b001;
    @(posedge clk); #1;
    chk(c_rt == 1 && sq_v == 0, "R9 correct branch", {c_rt, sq_v}, 5'h2);
    @(negedge clk);

    clear_in();
    valid_i = 3'b001; ctrl_i = 3'b001; mispred_i = 3'b001; fault_i = 3'b001;
    #1;
    chk(fault_o == 3'b001 && done_o == 3'b001, "R8 fault_o", fault_o, 1);
    @(posedge clk); #1;
    chk(sq_v == 0, "R8 no squash", sq_v, 0);
    chk(c_wr == 0 && c_ex == 1, "R8 counters held", {c_wr, c_ex}, 1);
    @(negedge clk);

    clear_in();
    valid_i = 3'b010; mispred_i = 3'b010;
    @(posedge clk); #1;
    chk(err_fatal == 1 && sq_v == 0, "R7 fatal", {err_fatal, sq_v}, 2);
    @(negedge clk);

    clear_in();
    valid_i = 3'b011; ctrl_i = 3'b011; mispred_i = 3'b011;
    seq_i = {8'h00, 8'h55, 8'h44};
    #1;
    chk(done_o == 3'b001, "R2 second ctrl refused", done_o, 1);
    @(posedge clk); #1;
    chk(sq_v == 1 && sq_seq == 8'h45, "R2 squash from slot0", sq_seq, 8'h45);
    @(negedge clk);

    clear_in();
    valid_i = 3'b011; ser_i = 3'b001; ctrl_i = 3'b010; mispred_i = 3'b010;
    #1;
    chk(done_o == 3'b001, "R1 barrier", done_o, 1);
    @(posedge clk); #1;
    chk(sq_v == 0, "R1 no squash behind barrier", sq_v, 0);
    @(negedge clk);

    clear_in();
    valid_i = 3'b100; mem_i = 3'b100;
    #1;
    chk(done_o == 0, "R3 mem refused", done_o, 0);
    @(posedge clk); #1;
    chk(err_mem == 1, "R3 err_mem", err_mem, 1);
    @(negedge clk);
    finish_run();
  end
endmodule